// File: doc/BRIEF.md
# Character Display Host Write Port

This block is the host-facing write side of an eight-character dot-matrix display controller. A processor drives an 8-bit data bus, three digit-address lines, a mode line and four active-low controls (chip enable, write strobe, flash select, reset). The block keeps the character codes, a per-character flash bit and a small attribute register. It exports all of them in parallel to the scan and font logic.

The write strobe arrives asynchronously. It is synchronized to the system clock, and a write is committed on its rising edge. Two operations blank the display contents. Reset returns everything to its idle state. A control word with its top bit set starts a clear that keeps character and flash memory blank until a later control word drops the bit or a timed interval runs out. A busy output shows when clear is in force.

Top module: `dispif_top`

## Requirements
- R1: A write is committed only when the synchronized write strobe rises while chip enable is low. The bus values present at that rising edge are used, even if they differed earlier in the low pulse. The result is visible at the outputs within 8 clocks of the strobe rising. With chip enable high, nothing changes.
- R2: If flash select is high and the mode line is high, the data byte is stored in character entry `digitAddr`. On `charCodes`, entry i occupies bits [8i+7:8i]. Within an entry, bits 6:0 are the character code and bit 7 is the font page (0 = first, 1 = second).
- R3: If flash select is high and the mode line is low, the data byte loads the attribute register and `digitAddr` is ignored. The fields are: bits 2:0 to `brightSel`, bit 3 to `flashEna`, bit 4 to `blinkEna`, bit 6 to `lampTest`. Bit 5 has no output. Bit 7 is the clear request. Character and flash memory are untouched unless bit 7 is set.
- R4: If flash select is low, data bit 0 is stored as flash bit `digitAddr` on `flashBits`. The mode line and data bits 7:1 have no effect, and character memory and attributes are untouched.
- R5: While reset is low, all character entries read 20h, all flash bits read 0, every attribute field reads 0, `busy` reads 0 and `counterRst` reads 1. After reset is released, `counterRst` falls at the first clock edge.
- R6: An attribute write with bit 7 set makes every character entry 20h and every flash bit 0, raises `busy`, and stores bits 6:0 as in R3.
- R7: While `busy` is high, character and flash writes leave the memories at 20h and 0. Attribute writes still take effect.
- R8: An attribute write with bit 7 clear ends the clear at once: `busy` drops and later character and flash writes land normally.
- R9: Without a further attribute write, `busy` stays high for CLEAR_CYCLES clocks (150 by default) after the clear request and then falls. The attribute fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| ceN | input | 1 | Active-low chip enable |
| wrN | input | 1 | Active-low write strobe, asynchronous |
| flN | input | 1 | Active-low flash-memory select |
| modeSel | input | 1 | 1 = character memory, 0 = attribute register |
| digitAddr | input | 3 | Digit address |
| dataIn | input | 8 | Write data |
| charCodes | output | 64 | Eight character entries, entry i at [8i+7:8i] |
| flashBits | output | 8 | Per-digit flash bits |
| brightSel | output | 3 | Brightness code |
| flashEna | output | 1 | Character flash enable |
| blinkEna | output | 1 | Whole-display blink enable |
| lampTest | output | 1 | Lamp test enable |
| busy | output | 1 | Clear in force |
| counterRst | output | 1 | Reset pulse to scan timing |

## Verification
The bench first fills every character entry twice with arithmetic code patterns whose page bit varies, so a decode fault that swaps or aliases entries is detected. Next it runs all 128 attribute values with clear off, spreading each across different address values. This separates field-position errors from address leakage, and a check of the character memory after each write catches stray writes. Flash writes pass through every digit with random upper data bits and alternating mode values, so the bench can tell whether only bit 0 is used. Further checks cover chip enable held high, data changing inside the low strobe pulse, and writes during clear. The clear is ended once by an attribute write and once by the timer, with samples taken just before and just after the expected end.

// File: rtl/dispif_pkg.sv
package dispif_pkg;
  localparam int NUM_DIGITS = 8;
  localparam int CODE_W     = 8;
  localparam int ADDR_W     = $clog2(NUM_DIGITS);
  localparam logic [CODE_W-1:0] BLANK_CODE = 8'h20;

  typedef struct packed {
    logic              blankAll;
    logic              wrChar;
    logic              wrFlash;
    logic              wrCtrl;
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] data;
  } dispStrobe_t;
endpackage

// File: rtl/dispif_ctrl.sv
module dispif_ctrl
  import dispif_pkg::*;
#(
  parameter int CLEAR_CYCLES = 150,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              wrN,
  input  logic              flN,
  input  logic              modeSel,
  input  logic [ADDR_W-1:0] digitAddr,
  input  logic [CODE_W-1:0] dataIn,
  output dispStrobe_t       strobe,
  output logic              busy,
  output logic              counterRst
);
  localparam int CNT_W = $clog2(CLEAR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CLEAR_CYCLES - 1);

  logic [SYNC_STAGES:0] wrPipe;
  logic wrRise, accept, isChar, isFlash, isCtrl;
  logic clearActive;
  logic [CNT_W-1:0] clearCnt;
  logic wrCharQ, wrFlashQ, wrCtrlQ;
  logic [ADDR_W-1:0] addrQ;
  logic [CODE_W-1:0] dataQ;
  logic rstHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrPipe <= '1;
    else       wrPipe <= {wrPipe[SYNC_STAGES-1:0], wrN};
  end

  assign wrRise  = wrPipe[SYNC_STAGES-1] & ~wrPipe[SYNC_STAGES];
  assign accept  = wrRise & ~ceN;
  assign isFlash = accept & ~flN;
  assign isChar  = accept & flN & modeSel;
  assign isCtrl  = accept & flN & ~modeSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clearActive <= 1'b0;
      clearCnt    <= '0;
    end else if (isCtrl) begin
      clearActive <= dataIn[CODE_W-1];
      clearCnt    <= CNT_LOAD;
    end else if (clearActive) begin
      if (clearCnt == '0) clearActive <= 1'b0;
      else                clearCnt    <= clearCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCharQ  <= 1'b0;
      wrFlashQ <= 1'b0;
      wrCtrlQ  <= 1'b0;
      addrQ    <= '0;
      dataQ    <= '0;
    end else begin
      wrCharQ  <= isChar;
      wrFlashQ <= isFlash;
      wrCtrlQ  <= isCtrl;
      if (accept) begin
        addrQ <= digitAddr;
        dataQ <= dataIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstHold <= 1'b1;
    else       rstHold <= 1'b0;
  end

  always_comb begin
    strobe.blankAll = clearActive;
    strobe.wrChar   = wrCharQ;
    strobe.wrFlash  = wrFlashQ;
    strobe.wrCtrl   = wrCtrlQ;
    strobe.addr     = addrQ;
    strobe.data     = dataQ;
  end

  assign busy       = clearActive;
  assign counterRst = rstHold;

  // R6
  clear_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isCtrl && dataIn[CODE_W-1]) |=> busy);

  // R8
  clear_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isCtrl && !dataIn[CODE_W-1]) |=> !busy);

  // R9
  clear_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clearActive && !isCtrl && clearCnt != '0) |=> busy);

  // R1
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCharQ || wrFlashQ || wrCtrlQ) |=> !(wrCharQ || wrFlashQ || wrCtrlQ));

  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrCharQ, wrFlashQ, wrCtrlQ}));
endmodule

// File: rtl/dispif_data.sv
module dispif_data
  import dispif_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  dispStrobe_t                  strobe,
  output logic [NUM_DIGITS*CODE_W-1:0] charCodes,
  output logic [NUM_DIGITS-1:0]        flashBits,
  output logic [2:0]                   brightSel,
  output logic                         flashEna,
  output logic                         blinkEna,
  output logic                         lampTest
);
  logic unusedSpare;
  assign unusedSpare = strobe.data[5];

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    logic [CODE_W-1:0] entry;
    logic              flashQ;
    logic              hit;
    assign hit = (strobe.addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     entry <= BLANK_CODE;
      else if (strobe.blankAll)      entry <= BLANK_CODE;
      else if (strobe.wrChar && hit) entry <= strobe.data;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                      flashQ <= 1'b0;
      else if (strobe.blankAll)       flashQ <= 1'b0;
      else if (strobe.wrFlash && hit) flashQ <= strobe.data[0];
    end

    assign charCodes[g*CODE_W +: CODE_W] = entry;
    assign flashBits[g]                  = flashQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brightSel <= '0;
      flashEna  <= 1'b0;
      blinkEna  <= 1'b0;
      lampTest  <= 1'b0;
    end else if (strobe.wrCtrl) begin
      brightSel <= strobe.data[2:0];
      flashEna  <= strobe.data[3];
      blinkEna  <= strobe.data[4];
      lampTest  <= strobe.data[6];
    end
  end

  // R2
  char_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrChar && !strobe.blankAll) |=>
      charCodes[$past(strobe.addr)*CODE_W +: CODE_W] == $past(strobe.data));

  // R4
  flash_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrFlash && !strobe.blankAll) |=>
      flashBits[$past(strobe.addr)] == $past(strobe.data[0]));

  // R6
  blank_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.blankAll |=> (flashBits == '0) && (charCodes == {NUM_DIGITS{BLANK_CODE}}));

  // R3
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrCtrl |=> $stable({lampTest, blinkEna, flashEna, brightSel}));
endmodule

// File: rtl/dispif_top.sv
module dispif_top
  import dispif_pkg::*;
#(
  parameter int CLEAR_CYCLES = 150,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        wrN,
  input  logic        flN,
  input  logic        modeSel,
  input  logic [2:0]  digitAddr,
  input  logic [7:0]  dataIn,
  output logic [63:0] charCodes,
  output logic [7:0]  flashBits,
  output logic [2:0]  brightSel,
  output logic        flashEna,
  output logic        blinkEna,
  output logic        lampTest,
  output logic        busy,
  output logic        counterRst
);
  dispStrobe_t strobe;

  dispif_ctrl #(.CLEAR_CYCLES(CLEAR_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .wrN(wrN), .flN(flN),
    .modeSel(modeSel), .digitAddr(digitAddr), .dataIn(dataIn),
    .strobe(strobe), .busy(busy), .counterRst(counterRst)
  );

  dispif_data u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .charCodes(charCodes), .flashBits(flashBits), .brightSel(brightSel),
    .flashEna(flashEna), .blinkEna(blinkEna), .lampTest(lampTest)
  );
endmodule

// File: tb/dispif_top_test.sv
module dispif_top_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, wrN = 1'b1, flN = 1'b1, modeSel = 1'b0;
  logic [2:0] digitAddr = '0;
  logic [7:0] dataIn = '0;
  logic [63:0] charCodes;
  logic [7:0] flashBits;
  logic [2:0] brightSel;
  logic flashEna, blinkEna, lampTest, busy, counterRst;

  int nRun = 0, nFail = 0;
  bit finished = 1'b0;
  logic [7:0] expChar [8];
  logic [7:0] expFlash;
  logic [6:0] expCtrl;

  always #10 clk = ~clk;

  dispif_top uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .wrN(wrN), .flN(flN),
    .modeSel(modeSel), .digitAddr(digitAddr), .dataIn(dataIn),
    .charCodes(charCodes), .flashBits(flashBits), .brightSel(brightSel),
    .flashEna(flashEna), .blinkEna(blinkEna), .lampTest(lampTest),
    .busy(busy), .counterRst(counterRst)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] packChars();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = expChar[i];
    return v;
  endfunction

  task automatic checkAll(input string tag);
    chk({tag, " chars"}, charCodes, packChars());
    chk({tag, " flash"}, {56'd0, flashBits}, {56'd0, expFlash});
    chk({tag, " attr"}, {58'd0, lampTest, blinkEna, flashEna, brightSel},
        {58'd0, expCtrl[6], expCtrl[4], expCtrl[3], expCtrl[2:0]});
  endtask

  task automatic busWrite(input logic fl, input logic mode, input logic [2:0] a,
                          input logic [7:0] d, input logic ce);
    @(negedge clk);
    ceN = ce; flN = fl; modeSel = mode; digitAddr = a; dataIn = d; wrN = 1'b0;
    repeat (3) @(negedge clk);
    wrN = 1'b1;
    repeat (6) @(negedge clk);
    ceN = 1'b1; flN = 1'b1;
  endtask

  task automatic resetModel();
    for (int i = 0; i < 8; i++) expChar[i] = 8'h20;
    expFlash = '0;
    expCtrl = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    resetModel();
    repeat (3) @(negedge clk);
    chk("R5 counterRst in reset", {63'd0, counterRst}, 64'd1);
    checkAll("R5 in reset");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 counterRst after release", {63'd0, counterRst}, 64'd0);
    chk("R5 busy after reset", {63'd0, busy}, 64'd0);
    checkAll("R5 after release");

    // R2: two fills of every entry, page bit varies
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < 8; a++) begin
        logic [7:0] d;
        d = 8'((a * 37 + pass * 101 + 5) & 255);
        busWrite(1'b1, 1'b1, 3'(a), d, 1'b0);
        expChar[a] = d;
        checkAll("R2 char fill");
      end
    end

    // R1: chip enable high blocks every kind of write
    busWrite(1'b1, 1'b1, 3'd2, 8'h55, 1'b1);
    checkAll("R1 ce high char");
    busWrite(1'b0, 1'b1, 3'd2, 8'h01, 1'b1);
    checkAll("R1 ce high flash");
    busWrite(1'b1, 1'b0, 3'd0, 8'h5F, 1'b1);
    checkAll("R1 ce high attr");

    // R1: value at strobe rise wins
    @(negedge clk);
    ceN = 1'b0; flN = 1'b1; modeSel = 1'b1; digitAddr = 3'd4; dataIn = 8'h11; wrN = 1'b0;
    repeat (2) @(negedge clk);
    dataIn = 8'h6A;
    repeat (2) @(negedge clk);
    wrN = 1'b1;
    repeat (8) @(negedge clk);
    ceN = 1'b1;
    expChar[4] = 8'h6A;
    checkAll("R1 capture at rise");

    // R3: all attribute values without clear
    for (int v = 0; v < 128; v++) begin
      busWrite(1'b1, 1'b0, 3'((v * 3) & 7), 8'(v), 1'b0);
      expCtrl = 7'(v);
      checkAll("R3 attr sweep");
    end

    // R4: flash bits, upper bits and mode random
    for (int a = 0; a < 8; a++) begin
      logic [7:0] d;
      d = 8'(((a * 29 + 77) & 254) | ((a & 1) ^ 1));
      busWrite(1'b0, 1'(a & 1), 3'(a), d, 1'b0);
      expFlash[a] = d[0];
      checkAll("R4 flash write");
    end
    busWrite(1'b0, 1'b0, 3'd0, 8'hFE, 1'b0);
    expFlash[0] = 1'b0;
    checkAll("R4 flash clear bit");

    // R6: clear request
    busWrite(1'b1, 1'b0, 3'd5, 8'hDB, 1'b0);
    resetModel();
    expCtrl = 7'h5B;
    chk("R6 busy", {63'd0, busy}, 64'd1);
    checkAll("R6 clear");

    // R7: writes during clear are blanked
    busWrite(1'b1, 1'b1, 3'd3, 8'h41, 1'b0);
    checkAll("R7 char in clear");
    busWrite(1'b0, 1'b0, 3'd6, 8'h01, 1'b0);
    checkAll("R7 flash in clear");
    chk("R7 still busy", {63'd0, busy}, 64'd1);

    // R8: attribute write with top bit clear ends clear
    busWrite(1'b1, 1'b0, 3'd1, 8'h02, 1'b0);
    expCtrl = 7'h02;
    chk("R8 busy dropped", {63'd0, busy}, 64'd0);
    checkAll("R8 attr");
    busWrite(1'b1, 1'b1, 3'd3, 8'h41, 1'b0);
    expChar[3] = 8'h41;
    busWrite(1'b0, 1'b1, 3'd1, 8'h03, 1'b0);
    expFlash[1] = 1'b1;
    checkAll("R8 writes resume");

    // R9: timed end of clear
    busWrite(1'b1, 1'b0, 3'd0, 8'h87, 1'b0);
    resetModel();
    expCtrl = 7'h07;
    checkAll("R9 clear start");
    repeat (135) @(negedge clk);
    chk("R9 busy before expiry", {63'd0, busy}, 64'd1);
    repeat (15) @(negedge clk);
    chk("R9 busy after expiry", {63'd0, busy}, 64'd0);
    checkAll("R9 attr kept");
    busWrite(1'b1, 1'b1, 3'd7, 8'hC1, 1'b0);
    expChar[7] = 8'hC1;
    checkAll("R9 write after expiry");

    // R5: reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    resetModel();
    @(negedge clk);
    chk("R5 counterRst mid reset", {63'd0, counterRst}, 64'd1);
    checkAll("R5 mid reset");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 counterRst released", {63'd0, counterRst}, 64'd0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule